// File: doc/BRIEF.md
# Dual-Channel Byte Packer for a Longword Transfer Stream

This block collects bytes from a bank of thirteen byte-wide source streams and assembles them into 32-bit longwords for a downstream transfer FIFO. It has two independent channels. Each channel is armed by writing a control register with a source code and a byte count. The channel then pulls that many bytes from the chosen source and packs four bytes into each longword.

When a count ends partway through a longword, the unused lanes are padded with zero bytes. A per-channel counter records how many padding bytes were added. A shared control register sets the lane order of the first byte and holds a level that partially clears the downstream transfer FIFO. When both channels have a longword ready, they take turns on the single output stream.

Software programs the registers and reads back the live remaining count. Sources and the output both use valid/ready handshakes.

Top module: `dma_byte_packer`

## Requirements
- R1: After reset, both channel control registers and both fill-count registers read 0, the shared register reads 0x2, no source is given ready, and the output is not valid.
- R2: A channel control register holds the source code in bits 20..17 and the byte count in bits 16..0 (word address 0 for channel 0, 1 for channel 1). Codes 0 to 12 select the source of that index, and ready is given only to the selected source.
- R3: Source codes 13, 14 and 15 select no source. With a nonzero count, such a channel takes no byte, emits nothing and keeps its count unchanged.
- R4: Reading a channel control register returns the live remaining count. The count drops by one for each byte accepted. At zero the channel stops taking bytes.
- R5: With shared bit 0 at 0, the first byte of each longword appears in bits 31..24 and the fourth byte in bits 7..0.
- R6: With shared bit 0 at 1, the first byte of each longword appears in bits 7..0 and the fourth byte in bits 31..24.
- R7: When a count ends inside a longword, the remaining lanes are filled with 0x00. The fill-count register of that channel (word address 2 for channel 0, 3 for channel 1, bits 16..0) adds one per padding byte. Writing a nonzero count clears it.
- R8: When both channels have traffic, output longwords alternate between the channels, and each channel's longwords keep their own byte order.
- R9: While the output is valid and not ready, the output stays valid and its data holds stable.
- R10: The shared register is at word address 4. While its bit 1 is 0, the partial-clear output to the transfer FIFO is high, and it is low while bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| src_data_i | input | 104 | Source bytes, source s in bits 8s+7..8s |
| src_valid_i | input | 13 | Source valid, one bit per source |
| src_ready_o | output | 13 | Source ready, one bit per source |
| out_data_o | output | 32 | Packed longword |
| out_valid_o | output | 1 | Longword valid |
| out_ready_i | input | 1 | Downstream ready |
| xfer_flush_o | output | 1 | Partial clear level for the transfer FIFO |

## Verification
Two functions can fall in the same cycle: the output is held stalled while the other channel completes its longword and starts requesting. The arbiter must then keep the stalled grant and not switch sources under a valid word. The bench provokes this by arming both channels with the output held not ready and then releasing single-cycle ready pulses. It judges the result by the exact order and content of the four longwords collected, and by sampling the stalled output on consecutive cycles.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = 32;
  localparam logic [1:0]  SHARED_RST = 2'b10;
endpackage

// File: rtl/dma_pack_chan.sv
module dma_pack_chan
  import dma_pack_pkg::*;
#(
  parameter int unsigned N_SRC = 13,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned CNT_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_vld_i,
  input  logic              block_i,
  input  logic              pop_i,
  output logic              want_o,
  output logic              take_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CNT_W-1:0]  rem_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int unsigned IDX_W = $clog2(LANES);

  logic [LANES-1:0][7:0] buf_q;
  logic [IDX_W-1:0]      idx_q;
  logic [LANES-1:0][7:0] packed_w;
  logic                  last_byte, word_done;

  assign want_o    = (rem_o != '0) && (sel_o < SEL_W'(N_SRC)) && !word_vld_o;
  assign take_o    = want_o && !block_i && byte_vld_i;
  assign last_byte = (rem_o == CNT_W'(1));
  assign word_done = (idx_q == IDX_W'(LANES - 1)) || last_byte;

  // lanes below idx from buffer, idx gets new byte, above idx zero
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (IDX_W'(k) < idx_q)       packed_w[k] = buf_q[k];
      else if (IDX_W'(k) == idx_q) packed_w[k] = byte_i;
      else                         packed_w[k] = 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o      <= '0;
      rem_o      <= '0;
      fill_o     <= '0;
      buf_q      <= '0;
      idx_q      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      if (pop_i) word_vld_o <= 1'b0;
      if (wr_i) begin
        sel_o <= wr_sel_i;
        rem_o <= wr_cnt_i;
        idx_q <= '0;
        buf_q <= '0;
        if (wr_cnt_i != '0) fill_o <= '0;
      end else if (take_o) begin
        rem_o <= rem_o - CNT_W'(1);
        if (word_done) begin
          word_o     <= packed_w;
          word_vld_o <= 1'b1;
          idx_q      <= '0;
          buf_q      <= '0;
          if (last_byte) fill_o <= fill_o + CNT_W'(IDX_W'(LANES - 1) - idx_q);
        end else begin
          buf_q[idx_q] <= byte_i;
          idx_q        <= idx_q + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dma_pack_arb.sv
module dma_pack_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic       ready_i,
  output logic [1:0] gnt_o,
  output logic       valid_o
);
  logic       last_q;
  logic       lock_q;
  logic [1:0] gnt_q;

  assign valid_o = |req_i;

  always_comb begin
    if (lock_q)              gnt_o = gnt_q;
    else if (req_i == 2'b11) gnt_o = last_q ? 2'b01 : 2'b10;
    else                     gnt_o = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b1;
      lock_q <= 1'b0;
      gnt_q  <= '0;
    end else begin
      lock_q <= valid_o && !ready_i;
      gnt_q  <= gnt_o;
      if (valid_o && ready_i) last_q <= gnt_o[1];
    end
  end
endmodule

// File: rtl/dma_byte_packer.sv
module dma_byte_packer
  import dma_pack_pkg::*;
#(
  parameter int unsigned N_SRC  = 13,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned CNT_W  = 17,
  parameter int unsigned ADDR_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [N_SRC*8-1:0] src_data_i,
  input  logic [N_SRC-1:0]   src_valid_i,
  output logic [N_SRC-1:0]   src_ready_o,
  output logic [WORD_W-1:0]  out_data_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               xfer_flush_o
);
  localparam int unsigned N_CH     = 2;
  localparam int unsigned SEL_LSB  = CNT_W;
  localparam int unsigned A_FILL   = N_CH;
  localparam int unsigned A_SHARED = 2 * N_CH;

  logic [N_CH-1:0][SEL_W-1:0]  ch_sel;
  logic [N_CH-1:0][CNT_W-1:0]  ch_rem, ch_fill;
  logic [N_CH-1:0][WORD_W-1:0] ch_word;
  logic [N_CH-1:0][7:0]        ch_byte;
  logic [N_CH-1:0] ch_wvld, ch_want, ch_take, ch_pop, ch_wr, ch_block, ch_sv;
  logic [N_CH-1:0] gnt;
  logic [1:0]      shared_q;
  logic [7:0]      src_b [N_SRC];
  logic [WORD_W-1:0] word_sel;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_b[s] = src_data_i[s*8 +: 8];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic sel_ok;
    assign sel_ok     = ch_sel[c] < SEL_W'(N_SRC);
    assign ch_byte[c] = sel_ok ? src_b[ch_sel[c]] : 8'h00;
    assign ch_sv[c]   = sel_ok && src_valid_i[ch_sel[c]];
    assign ch_wr[c]   = reg_we_i && (reg_addr_i == ADDR_W'(c));
    assign ch_pop[c]  = gnt[c] && out_ready_i;

    dma_pack_chan #(.N_SRC(N_SRC), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (ch_wr[c]),
      .wr_sel_i   (reg_wdata_i[SEL_LSB +: SEL_W]),
      .wr_cnt_i   (reg_wdata_i[CNT_W-1:0]),
      .byte_i     (ch_byte[c]),
      .byte_vld_i (ch_sv[c]),
      .block_i    (ch_block[c]),
      .pop_i      (ch_pop[c]),
      .want_o     (ch_want[c]),
      .take_o     (ch_take[c]),
      .sel_o      (ch_sel[c]),
      .rem_o      (ch_rem[c]),
      .fill_o     (ch_fill[c]),
      .word_o     (ch_word[c]),
      .word_vld_o (ch_wvld[c])
    );
  end

  // lower channel wins a source both channels point at
  always_comb begin
    ch_block = '0;
    for (int c = 1; c < N_CH; c++)
      for (int d = 0; d < c; d++)
        if (ch_want[d] && ch_sel[d] == ch_sel[c]) ch_block[c] = 1'b1;
  end

  always_comb begin
    src_ready_o = '0;
    for (int s = 0; s < N_SRC; s++)
      for (int c = 0; c < N_CH; c++)
        if (ch_take[c] && ch_sel[c] == SEL_W'(s)) src_ready_o[s] = 1'b1;
  end

  dma_pack_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (ch_wvld),
    .ready_i (out_ready_i),
    .gnt_o   (gnt),
    .valid_o (out_valid_o)
  );

  always_comb begin
    word_sel = '0;
    for (int c = 0; c < N_CH; c++)
      if (gnt[c]) word_sel = ch_word[c];
  end

  // channel words hold byte k in lane k; bit 0 low reverses lanes
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign out_data_o[k*8 +: 8] = shared_q[0] ? word_sel[k*8 +: 8]
                                              : word_sel[(LANES-1-k)*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shared_q <= SHARED_RST;
    else if (reg_we_i && reg_addr_i == ADDR_W'(A_SHARED)) shared_q <= reg_wdata_i[1:0];
  end

  assign xfer_flush_o = !shared_q[1];

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (reg_addr_i == ADDR_W'(c))          reg_rdata_o = 32'({ch_sel[c], ch_rem[c]});
      if (reg_addr_i == ADDR_W'(A_FILL + c)) reg_rdata_o = 32'(ch_fill[c]);
    end
    if (reg_addr_i == ADDR_W'(A_SHARED)) reg_rdata_o = 32'(shared_q);
  end
endmodule

// File: rtl/dma_byte_packer_chk.sv
module dma_byte_packer_chk #(
  parameter int unsigned N_SRC = 13,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned CNT_W = 17
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [N_SRC-1:0]     src_ready_o,
  input logic [31:0]          out_data_o,
  input logic                 out_valid_o,
  input logic                 out_ready_i,
  input logic [1:0][SEL_W-1:0] ch_sel,
  input logic [1:0][CNT_W-1:0] ch_rem,
  input logic [1:0][CNT_W-1:0] ch_fill
);
  logic idle0, idle1;
  assign idle0 = (ch_sel[0] >= SEL_W'(N_SRC)) || (ch_rem[0] == '0);
  assign idle1 = (ch_sel[1] >= SEL_W'(N_SRC)) || (ch_rem[1] == '0);

  a_r9_hold_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r2_ready_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(src_ready_o) <= 2);

  a_r3_idle_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle0 && idle1 |-> src_ready_o == '0);

  a_r4_rem_step0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> (ch_rem[0] == $past(ch_rem[0])) || (ch_rem[0] == $past(ch_rem[0]) - CNT_W'(1)));

  a_r4_rem_step1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> (ch_rem[1] == $past(ch_rem[1])) || (ch_rem[1] == $past(ch_rem[1]) - CNT_W'(1)));

  a_r7_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_fill[0] <= CNT_W'(3) && ch_fill[1] <= CNT_W'(3));
endmodule

bind dma_byte_packer dma_byte_packer_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .src_ready_o (src_ready_o),
  .out_data_o  (out_data_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .ch_sel      (ch_sel),
  .ch_rem      (ch_rem),
  .ch_fill     (ch_fill)
);

// File: tb/sim_dma_byte_packer.sv
`timescale 1ns/1ps
module sim_dma_byte_packer;
  localparam int NS = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NS*8-1:0] src_data;
  logic [NS-1:0]   src_valid = '1;
  logic [NS-1:0]   src_ready;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        flush;

  int tests = 0, fails = 0, cycles = 0;
  logic        col_clr = 1'b0;
  logic [3:0]  scnt [NS];
  logic [31:0] wq [16];
  int          wcnt;

  always #2.5 clk = ~clk;

  dma_byte_packer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_data_i(src_data),
    .src_valid_i(src_valid), .src_ready_o(src_ready), .out_data_o(out_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .xfer_flush_o(flush)
  );

  // source s emits {s, k} for its k-th byte since the last clear
  always_comb
    for (int s = 0; s < NS; s++) src_data[s*8 +: 8] = {4'(s), scnt[s]};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (col_clr) begin
      wcnt <= 0;
      for (int s = 0; s < NS; s++) scnt[s] <= '0;
    end else begin
      if (out_valid && out_ready && wcnt < 16) begin
        wq[wcnt] <= out_data;
        wcnt <= wcnt + 1;
      end
      for (int s = 0; s < NS; s++)
        if (src_valid[s] && src_ready[s]) scnt[s] <= scnt[s] + 4'd1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [31:0] ctl(int sel, int cnt);
    return (32'(sel) << 17) | 32'(cnt);
  endfunction

  task automatic clr();
    @(negedge clk); col_clr = 1'b1;
    @(negedge clk); col_clr = 1'b0;
  endtask

  task automatic wait_words(int n);
    for (int i = 0; i < 300 && wcnt < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d); chk("R1 reg zero", d, 0);
    end
    rd(3'd4, d); chk("R1 shared", d, 32'h2);
    chk("R1 ready", 32'(src_ready), 0);
    chk("R1 valid", 32'(out_valid), 0);
  endtask

  task automatic t_order_be();
    logic [31:0] d;
    bit other = 0, seen = 0;
    clr();
    wr(3'd0, ctl(2, 8));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (src_ready & ~13'h0004) other = 1;
      if (src_ready[2]) seen = 1;
    end
    chk("R2 only selected ready", 32'({other, seen}), 32'b01);
    wait_words(2);
    chk("R5 word0", wq[0], 32'h20212223);
    chk("R5 word1", wq[1], 32'h24252627);
    rd(3'd0, d); chk("R4 count at end", d, ctl(2, 0));
    rd(3'd2, d); chk("R7 no fill on full words", d, 0);
    chk("R4 stopped", 32'(src_ready), 0);
  endtask

  task automatic t_order_le();
    clr();
    wr(3'd4, 32'h3);
    wr(3'd0, ctl(5, 4));
    wait_words(1);
    chk("R6 word0", wq[0], 32'h53525150);
    wr(3'd4, 32'h2);
  endtask

  task automatic t_pad();
    logic [31:0] d;
    clr();
    wr(3'd1, ctl(12, 5));
    wait_words(2);
    chk("R2 source 12 word0", wq[0], 32'hC0C1C2C3);
    chk("R7 padded word", wq[1], 32'hC4000000);
    rd(3'd3, d); chk("R7 fill three", d, 3);
    wr(3'd1, ctl(12, 4));
    rd(3'd3, d); chk("R7 fill cleared", d, 0);
    wait_words(3);
  endtask

  task automatic t_nosrc();
    logic [31:0] d;
    bit any = 0;
    clr();
    wr(3'd0, ctl(13, 7));
    wr(3'd1, ctl(15, 3));
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (src_ready != 0 || out_valid) any = 1;
    end
    chk("R3 no traffic", 32'(any), 0);
    rd(3'd0, d); chk("R3 count held ch0", d, ctl(13, 7));
    rd(3'd1, d); chk("R3 count held ch1", d, ctl(15, 3));
    wr(3'd0, 0);
    wr(3'd1, 0);
  endtask

  task automatic t_live();
    logic [31:0] d, h0, h1;
    clr();
    @(negedge clk); out_ready = 1'b0;
    wr(3'd0, ctl(1, 6));
    repeat (10) @(negedge clk);
    rd(3'd0, d); chk("R4 live count", d, ctl(1, 2));
    h0 = out_data;
    @(negedge clk); h1 = out_data;
    chk("R9 valid held", 32'(out_valid), 1);
    chk("R9 data held", h1, h0);
    chk("R9 data value", h1, 32'h10111213);
    @(negedge clk); out_ready = 1'b1;
    wait_words(2);
    chk("R7 second word", wq[1], 32'h14150000);
    rd(3'd2, d); chk("R7 fill two", d, 2);
  endtask

  task automatic t_rr();
    clr();
    @(negedge clk); out_ready = 1'b0;
    wr(3'd1, ctl(1, 8));
    wr(3'd0, ctl(0, 8));
    repeat (10) @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); out_ready = 1'b1;
      @(negedge clk); out_ready = 1'b0;
      repeat (10) @(negedge clk);
    end
    out_ready = 1'b1;
    chk("R8 count", 32'(wcnt), 4);
    chk("R8 w0", wq[0], 32'h10111213);
    chk("R8 w1", wq[1], 32'h00010203);
    chk("R8 w2", wq[2], 32'h14151617);
    chk("R8 w3", wq[3], 32'h04050607);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    wr(3'd4, 32'h0);
    rd(3'd4, d); chk("R10 read zero", d, 0);
    chk("R10 flush high", 32'(flush), 1);
    wr(3'd4, 32'h2);
    chk("R10 flush low", 32'(flush), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_be();
    t_order_le();
    t_pad();
    t_nosrc();
    t_live();
    t_rr();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=<50000", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule